// File: doc/BRIEF.md
# Multi-Bus Slot Hotplug Status Registers

This block gives firmware a small register window for tracking slot insertion and removal across several expansion buses. For every bus it keeps three slot bitmaps: slots with a pending insertion, slots with a pending removal request, and slots that may be removed at all. A bus-select register picks which bus the bitmap registers show. Side-band event inputs, driven by the platform's slot management logic, report insertions and removal requests by bus and slot. Each event yields a one-cycle event pulse that can feed an interrupt controller.

Firmware completes a removal by writing a slot mask to the eject register. The block takes the lowest set bit of the mask, clears that slot's pending bits and, if the slot is hotpluggable, emits a one-cycle eject strobe tagged with bus and slot. A platform-reset drain sequence, started by a pulse, walks all buses and ejects every pending removal one slot at a time. It then rebuilds the removable masks from the per-bus fixed-slot input. A legacy mode input keeps insertion bits sticky on read and pins the bus select to bus 0.

Top module: `hp_status_regs`

## Requirements
- R1: After reset every pending bitmap is zero, the select register is 0, each removable mask equals the bitwise complement of that bus's fixed-slot mask, and the event pulse, eject strobe and drain busy outputs are low.
- R2: A plug event sets the insertion bit of its bus and slot. An unplug-request event sets the removal-request bit. Either event drives evt_pulse high for exactly the following cycle.
- R3: A read is answered the cycle after the request with rsp_valid high. The register offsets are 0x00 insertion bitmap, 0x04 removal-request bitmap, 0x08 eject (reads 0), 0x0C removable mask and 0x10 bus select. Any other offset reads 0.
- R4: Reading the insertion bitmap returns the selected bus's pending bits and clears them when legacy_mode is 0. When legacy_mode is 1 the bits are kept.
- R5: A plug event on the selected bus that lands in the same cycle as a clearing read of the insertion bitmap leaves the new bit set. The read returns only the bits pending before that cycle.
- R6: When the select value is at or above the bus count (8), every read returns 0, the select register included, and eject writes have no effect.
- R7: An eject write uses only the lowest set bit of the data. It clears that slot's insertion and removal-request bits on the selected bus. If the slot is not fixed, ej_valid is high the next cycle with ej_bus and ej_slot. A write of zero does nothing.
- R8: With legacy_mode at 1, a write to the select register loads 0 whatever the data.
- R9: Only accesses with all four byte enables set take effect. Other writes are ignored, and other reads are answered with data 0.
- R10: A drain_start pulse raises drain_busy. The drain then goes through buses in ascending order, and within a bus ejects pending removals lowest slot first, one per cycle. Each ejected slot gets the R7 treatment. At the end the removable masks are reloaded from the current fixed-slot input and drain_busy falls. Register accesses made while busy read 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Sticky insertion bits and select forced to 0 |
| fixed_mask | input | 256 | Per-bus non-hotpluggable slots, bus b at bits [32b+31:32b] |
| plug_valid | input | 1 | Insertion event |
| plug_bus | input | 3 | Bus of insertion event |
| plug_slot | input | 5 | Slot of insertion event |
| unplug_valid | input | 1 | Removal-request event |
| unplug_bus | input | 3 | Bus of removal request |
| unplug_slot | input | 5 | Slot of removal request |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset in the window |
| reg_be | input | 4 | Byte enables, must be all ones |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| drain_start | input | 1 | Starts the removal drain sequence |
| drain_busy | output | 1 | Drain in progress |
| evt_pulse | output | 1 | One-cycle event notification |
| ej_valid | output | 1 | One-cycle eject strobe |
| ej_bus | output | 3 | Bus of ejected slot |
| ej_slot | output | 5 | Slot of ejected slot |

## Verification
The hardest situation to reach is the drain walk with pending removals spread over several buses, some in fixed slots. The ordering and the suppressed strobes only show if the earlier directed tests leave removal requests behind on purpose. The bench plants requests on buses 0, 2 and 5, including one in a fixed slot. It also changes the fixed mask of an untouched bus, logs every eject strobe during the drain, and compares the log with the expected bus-then-slot order. A second case that is hard to reach is the collision of a clearing read with a new plug event. The bench drives both in the same cycle, then reads twice to separate the old value from the surviving bit.

// File: rtl/hp_pkg.sv
// Package: register offsets and decode shared by the hotplug status block.
// Assumes byte addressing of a 0x14-byte window with 32-bit registers.
package hp_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        K_UP    = 3'd0,
        K_DOWN  = 3'd1,
        K_EJECT = 3'd2,
        K_RMV   = 3'd3,
        K_SEL   = 3'd4,
        K_NONE  = 3'd5
    } reg_kind_e;

    // Map a byte offset onto the register it addresses.
    function automatic reg_kind_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            5'h00:   decode_addr = K_UP;
            5'h04:   decode_addr = K_DOWN;
            5'h08:   decode_addr = K_EJECT;
            5'h0C:   decode_addr = K_RMV;
            5'h10:   decode_addr = K_SEL;
            default: decode_addr = K_NONE;
        endcase
    endfunction
endpackage

// File: rtl/hp_lowbit.sv
// Module: lowest-set-bit finder (count of trailing zeros) over a W-bit vector.
// Assumes W >= 2; idx is 0 when found is low.
module hp_lowbit #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the last hit is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hp_slot_bank.sv
// Module: one bus's insertion, removal-request and removable bitmaps.
// Assumes set inputs win over clear inputs in the same cycle.
module hp_slot_bank #(
    parameter int NUM_SLOT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SLOT-1:0] fixed,
    input  logic [NUM_SLOT-1:0] set_up,
    input  logic [NUM_SLOT-1:0] set_down,
    input  logic                clr_up_all,
    input  logic [NUM_SLOT-1:0] clr_slot,
    input  logic                load_rmv,
    output logic [NUM_SLOT-1:0] up_q,
    output logic [NUM_SLOT-1:0] down_q,
    output logic [NUM_SLOT-1:0] rmv_q
);
    logic [NUM_SLOT-1:0] up_keep;

    // Bits surviving this cycle's read-clear and eject-clear.
    always_comb begin
        up_keep = clr_up_all ? '0 : up_q;
        up_keep = up_keep & ~clr_slot;
    end

    // Update pending bitmaps; new events take priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q   <= '0;
            down_q <= '0;
        end else begin
            up_q   <= up_keep | set_up;
            down_q <= (down_q & ~clr_slot) | set_down;
        end
    end

    // Removable mask: complement of fixed slots at reset and after a drain.
    always_ff @(posedge clk) begin
        if (!rst_n || load_rmv) rmv_q <= ~fixed;
    end
endmodule

// File: rtl/hp_drain_seq.sv
// Module: drain sequencer walking all buses and ejecting pending removals.
// Assumes 'found' reflects the current bus's removal bitmap combinationally.
module hp_drain_seq #(
    parameter int NUM_BUS = 8,
    localparam int BUS_W = $clog2(NUM_BUS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             found,
    output logic             busy,
    output logic [BUS_W-1:0] bus,
    output logic             eject,
    output logic             done
);
    localparam logic [BUS_W-1:0] LAST = BUS_W'(NUM_BUS - 1);

    // Eject while the current bus has work; finish after the last bus empties.
    always_comb begin
        eject = busy && found;
        done  = busy && !found && (bus == LAST);
    end

    // Step through buses once each has no pending removal left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bus  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                bus  <= '0;
            end
        end else if (!found) begin
            if (bus == LAST) busy <= 1'b0;
            else             bus  <= bus + 1'b1;
        end
    end
endmodule

// File: rtl/hp_status_regs.sv
// Module: multi-bus hotplug status register window for firmware.
// Assumes 32-bit registers, NUM_SLOT <= 32, NUM_BUS >= 2, and one access per cycle.
module hp_status_regs
    import hp_pkg::*;
#(
    parameter int NUM_BUS  = 8,
    parameter int NUM_SLOT = 32,
    localparam int BUS_W   = $clog2(NUM_BUS),
    localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         legacy_mode,
    input  logic [NUM_BUS*NUM_SLOT-1:0]  fixed_mask,
    input  logic                         plug_valid,
    input  logic [BUS_W-1:0]             plug_bus,
    input  logic [SLOT_W-1:0]            plug_slot,
    input  logic                         unplug_valid,
    input  logic [BUS_W-1:0]             unplug_bus,
    input  logic [SLOT_W-1:0]            unplug_slot,
    input  logic                         reg_req,
    input  logic                         reg_wr,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [3:0]                   reg_be,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_data,
    input  logic                         drain_start,
    output logic                         drain_busy,
    output logic                         evt_pulse,
    output logic                         ej_valid,
    output logic [BUS_W-1:0]             ej_bus,
    output logic [SLOT_W-1:0]            ej_slot
);
    logic [DATA_W-1:0]   sel_q;
    logic [NUM_SLOT-1:0] up_q   [NUM_BUS];
    logic [NUM_SLOT-1:0] down_q [NUM_BUS];
    logic [NUM_SLOT-1:0] rmv_q  [NUM_BUS];
    logic [NUM_BUS-1:0]  plug_hit, unplug_hit;

    reg_kind_e         kind;
    logic              acc_ok, rd_go, wr_go, sel_ok;
    logic [BUS_W-1:0]  sel_idx;
    logic [DATA_W-1:0] rd_val;

    logic              wr_found, wr_eject;
    logic [SLOT_W-1:0] wr_slot;
    logic              dr_found, dr_eject, dr_done;
    logic [BUS_W-1:0]  dr_bus;
    logic [SLOT_W-1:0] dr_slot;
    logic              ej_go, ej_fixed;
    logic [BUS_W-1:0]  ej_b;
    logic [SLOT_W-1:0] ej_s;

    // Access qualification and select range check.
    always_comb begin
        kind    = decode_addr(reg_addr);
        acc_ok  = reg_req && (reg_be == 4'hF) && !drain_busy;
        rd_go   = acc_ok && !reg_wr;
        wr_go   = acc_ok && reg_wr;
        sel_ok  = sel_q < DATA_W'(NUM_BUS);
        sel_idx = sel_q[BUS_W-1:0];
    end

    // Read mux for the selected bus.
    always_comb begin
        rd_val = '0;
        if (sel_ok) begin
            case (kind)
                K_UP:    rd_val = DATA_W'(up_q[sel_idx]);
                K_DOWN:  rd_val = DATA_W'(down_q[sel_idx]);
                K_RMV:   rd_val = DATA_W'(rmv_q[sel_idx]);
                K_SEL:   rd_val = sel_q;
                default: rd_val = '0;
            endcase
        end
    end

    hp_lowbit #(.W(NUM_SLOT)) u_wr_low (
        .vec   (reg_wdata[NUM_SLOT-1:0]),
        .found (wr_found),
        .idx   (wr_slot)
    );

    hp_drain_seq #(.NUM_BUS(NUM_BUS)) u_drain (
        .clk   (clk),
        .rst_n (rst_n),
        .start (drain_start),
        .found (dr_found),
        .busy  (drain_busy),
        .bus   (dr_bus),
        .eject (dr_eject),
        .done  (dr_done)
    );

    hp_lowbit #(.W(NUM_SLOT)) u_dr_low (
        .vec   (down_q[dr_bus]),
        .found (dr_found),
        .idx   (dr_slot)
    );

    // Merge the firmware eject and drain eject paths (mutually exclusive via busy).
    always_comb begin
        wr_eject = wr_go && (kind == K_EJECT) && sel_ok && wr_found;
        ej_go    = wr_eject || dr_eject;
        ej_b     = dr_eject ? dr_bus  : sel_idx;
        ej_s     = dr_eject ? dr_slot : wr_slot;
        ej_fixed = fixed_mask[int'(ej_b) * NUM_SLOT + int'(ej_s)];
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic [NUM_SLOT-1:0] set_up, set_down, clr_slot;
        logic                clr_up_all;

        // Per-bus set and clear vectors from events, reads and ejects.
        always_comb begin
            plug_hit[b]   = plug_valid   && (plug_bus   == BUS_W'(b));
            unplug_hit[b] = unplug_valid && (unplug_bus == BUS_W'(b));
            set_up        = plug_hit[b]   ? (NUM_SLOT'(1) << plug_slot)   : '0;
            set_down      = unplug_hit[b] ? (NUM_SLOT'(1) << unplug_slot) : '0;
            clr_slot      = (ej_go && ej_b == BUS_W'(b)) ? (NUM_SLOT'(1) << ej_s) : '0;
            clr_up_all    = rd_go && (kind == K_UP) && sel_ok &&
                            (sel_idx == BUS_W'(b)) && !legacy_mode;
        end

        hp_slot_bank #(.NUM_SLOT(NUM_SLOT)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .fixed      (fixed_mask[b*NUM_SLOT +: NUM_SLOT]),
            .set_up     (set_up),
            .set_down   (set_down),
            .clr_up_all (clr_up_all),
            .clr_slot   (clr_slot),
            .load_rmv   (dr_done),
            .up_q       (up_q[b]),
            .down_q     (down_q[b]),
            .rmv_q      (rmv_q[b])
        );
    end

    // Select register; legacy mode pins it to bus 0.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (wr_go && kind == K_SEL) sel_q <= legacy_mode ? '0 : reg_wdata;
    end

    // Read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= reg_req && !reg_wr;
            rsp_data  <= rd_go ? rd_val : '0;
        end
    end

    // Event pulse and eject strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
            ej_valid  <= 1'b0;
            ej_bus    <= '0;
            ej_slot   <= '0;
        end else begin
            evt_pulse <= (|plug_hit) || (|unplug_hit);
            ej_valid  <= ej_go && !ej_fixed;
            ej_bus    <= ej_b;
            ej_slot   <= ej_s;
        end
    end
endmodule

// File: rtl/hp_status_chk.sv
// Module: protocol checker for hp_status_regs, attached by bind.
// Assumes the default power-of-two bus count so every event bus is valid.
module hp_status_chk #(
    parameter int NUM_BUS  = 8,
    parameter int NUM_SLOT = 32,
    localparam int BUS_W   = $clog2(NUM_BUS),
    localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_BUS*NUM_SLOT-1:0] fixed_mask,
    input logic                        plug_valid,
    input logic                        unplug_valid,
    input logic                        reg_req,
    input logic                        reg_wr,
    input logic                        rsp_valid,
    input logic [31:0]                 rsp_data,
    input logic                        drain_start,
    input logic                        drain_busy,
    input logic                        evt_pulse,
    input logic                        ej_valid,
    input logic [BUS_W-1:0]            ej_bus,
    input logic [SLOT_W-1:0]           ej_slot
);
    logic [NUM_BUS*NUM_SLOT-1:0] fixed_prev;

    // Fixed mask as seen on the cycle an eject was decided.
    always_ff @(posedge clk) fixed_prev <= fixed_mask;

    // R2
    evt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_valid || unplug_valid) |=> evt_pulse);

    // R2
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> $past(plug_valid || unplug_valid));

    // R7
    ej_not_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> !fixed_prev[int'(ej_bus) * NUM_SLOT + int'(ej_slot)]);

    // R3
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(reg_req && !reg_wr));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_busy) |-> $past(drain_start));

    // R10
    busy_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(drain_busy)) |-> (rsp_data == 32'h0));
endmodule

bind hp_status_regs hp_status_chk #(.NUM_BUS(NUM_BUS), .NUM_SLOT(NUM_SLOT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fixed_mask   (fixed_mask),
    .plug_valid   (plug_valid),
    .unplug_valid (unplug_valid),
    .reg_req      (reg_req),
    .reg_wr       (reg_wr),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .drain_start  (drain_start),
    .drain_busy   (drain_busy),
    .evt_pulse    (evt_pulse),
    .ej_valid     (ej_valid),
    .ej_bus       (ej_bus),
    .ej_slot      (ej_slot)
);

// File: tb/tb_hp_status_regs.sv
module tb_hp_status_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         legacy_mode = 1'b0;
    logic [255:0] fixed_mask;
    logic         plug_valid = 1'b0, unplug_valid = 1'b0;
    logic [2:0]   plug_bus = '0, unplug_bus = '0;
    logic [4:0]   plug_slot = '0, unplug_slot = '0;
    logic         reg_req = 1'b0, reg_wr = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [3:0]   reg_be = 4'hF;
    logic [31:0]  reg_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic         drain_start = 1'b0;
    logic         drain_busy, evt_pulse, ej_valid;
    logic [2:0]   ej_bus;
    logic [4:0]   ej_slot;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;
    logic        logging = 1'b0;
    int          log_n = 0;
    logic [7:0]  log_e [16];

    always #5 clk = ~clk;

    hp_status_regs dut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .fixed_mask(fixed_mask),
        .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
        .unplug_valid(unplug_valid), .unplug_bus(unplug_bus), .unplug_slot(unplug_slot),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .drain_start(drain_start), .drain_busy(drain_busy), .evt_pulse(evt_pulse),
        .ej_valid(ej_valid), .ej_bus(ej_bus), .ej_slot(ej_slot)
    );

    // Record eject strobes during the drain test.
    always @(negedge clk) begin
        if (logging && ej_valid && log_n < 16) begin
            log_e[log_n] = {ej_bus, ej_slot};
            log_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks are entered at a negative edge and return at one.
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        reg_req = 1; reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_req = 0; reg_wr = 0; reg_be = 4'hF;
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        reg_req = 1; reg_wr = 0; reg_addr = a; reg_be = be;
        @(negedge clk);
        reg_req = 0; reg_be = 4'hF;
        chk("R3 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        d = rsp_data;
    endtask

    task automatic plug(input int b, input int s);
        plug_valid = 1; plug_bus = 3'(b); plug_slot = 5'(s);
        @(negedge clk);
        plug_valid = 0;
        chk("R2 evt_pulse plug", {31'b0, evt_pulse}, 32'h1);
    endtask

    task automatic unplug(input int b, input int s);
        unplug_valid = 1; unplug_bus = 3'(b); unplug_slot = 5'(s);
        @(negedge clk);
        unplug_valid = 0;
        chk("R2 evt_pulse unplug", {31'b0, evt_pulse}, 32'h1);
    endtask

    task automatic t_reset;
        rdreg(5'h00, rd); chk("R1 up after reset", rd, 32'h0);
        rdreg(5'h04, rd); chk("R1 down after reset", rd, 32'h0);
        rdreg(5'h0C, rd); chk("R1 removable after reset", rd, ~32'h8);
        rdreg(5'h10, rd); chk("R1 select after reset", rd, 32'h0);
        chk("R1 outputs low", {29'b0, evt_pulse, ej_valid, drain_busy}, 32'h0);
    endtask

    task automatic t_events;
        wr(5'h10, 32'd2);
        plug(2, 4); plug(2, 9); unplug(2, 6);
        @(negedge clk);
        chk("R2 evt_pulse single cycle", {31'b0, evt_pulse}, 32'h0);
        rdreg(5'h04, rd); chk("R2 down bit", rd, 32'h40);
        rdreg(5'h00, rd); chk("R2 up bits", rd, 32'h210);
        rdreg(5'h00, rd); chk("R4 up cleared by read", rd, 32'h0);
        rdreg(5'h08, rd); chk("R3 eject reads zero", rd, 32'h0);
        rdreg(5'h14, rd); chk("R3 unmapped reads zero", rd, 32'h0);
        rdreg(5'h0C, rd); chk("R3 removable bus2", rd, ~32'h20);
    endtask

    task automatic t_legacy;
        legacy_mode = 1;
        wr(5'h10, 32'd5);
        rdreg(5'h10, rd); chk("R8 legacy select forced 0", rd, 32'h0);
        plug(0, 1);
        rdreg(5'h00, rd); chk("R4 legacy up first read", rd, 32'h2);
        rdreg(5'h00, rd); chk("R4 legacy up kept", rd, 32'h2);
        legacy_mode = 0;
    endtask

    task automatic t_collide;
        wr(5'h10, 32'd4);
        plug(4, 2);
        reg_req = 1; reg_wr = 0; reg_addr = 5'h00;
        plug_valid = 1; plug_bus = 3'd4; plug_slot = 5'd5;
        @(negedge clk);
        reg_req = 0; plug_valid = 0;
        chk("R5 read returns old bits", rsp_data, 32'h4);
        rdreg(5'h00, rd); chk("R5 new bit survives clear", rd, 32'h20);
    endtask

    task automatic t_eject;
        wr(5'h10, 32'd1);
        unplug(1, 2); unplug(1, 8); plug(1, 8);
        wr(5'h08, 32'h104);
        chk("R7 strobe lowest bit", {ej_valid, ej_bus, ej_slot}, {1'b1, 3'd1, 5'd2});
        rdreg(5'h04, rd); chk("R7 only lowest cleared", rd, 32'h100);
        wr(5'h08, 32'h100);
        chk("R7 strobe slot 8", {ej_valid, ej_bus, ej_slot}, {1'b1, 3'd1, 5'd8});
        rdreg(5'h04, rd); chk("R7 down cleared", rd, 32'h0);
        rdreg(5'h00, rd); chk("R7 up cleared", rd, 32'h0);
        unplug(1, 4);
        wr(5'h08, 32'h10);
        chk("R7 fixed slot no strobe", {31'b0, ej_valid}, 32'h0);
        rdreg(5'h04, rd); chk("R7 fixed slot bits cleared", rd, 32'h0);
        wr(5'h08, 32'h0);
        chk("R7 zero data no strobe", {31'b0, ej_valid}, 32'h0);
    endtask

    task automatic t_range;
        unplug(3, 0);
        wr(5'h10, 32'd8);
        rdreg(5'h10, rd); chk("R6 select reads zero", rd, 32'h0);
        rdreg(5'h0C, rd); chk("R6 removable reads zero", rd, 32'h0);
        wr(5'h08, 32'h1);
        chk("R6 eject ignored", {31'b0, ej_valid}, 32'h0);
        wr(5'h10, 32'd3);
        rdreg(5'h04, rd); chk("R6 down kept", rd, 32'h1);
        wr(5'h08, 32'h1);
        chk("R7 eject bus3", {ej_valid, ej_bus, ej_slot}, {1'b1, 3'd3, 5'd0});
    endtask

    task automatic t_partial;
        wr(5'h10, 32'd5, 4'h3);
        rdreg(5'h10, rd); chk("R9 partial write ignored", rd, 32'h3);
        unplug(3, 2);
        rdreg(5'h04, rd, 4'h1); chk("R9 partial read zero", rd, 32'h0);
        rdreg(5'h04, rd); chk("R9 full read", rd, 32'h4);
        wr(5'h08, 32'h4);
    endtask

    task automatic t_drain;
        unplug(0, 3); unplug(0, 7); plug(0, 7); unplug(2, 1); unplug(5, 31);
        fixed_mask[6*32 +: 32] = 32'hFFFF_0000;
        log_n = 0; logging = 1;
        drain_start = 1;
        @(negedge clk);
        drain_start = 0;
        chk("R10 busy raised", {31'b0, drain_busy}, 32'h1);
        rdreg(5'h10, rd); chk("R10 read while busy zero", rd, 32'h0);
        wr(5'h10, 32'd6);
        for (int i = 0; i < 40 && drain_busy; i++) @(negedge clk);
        logging = 0;
        chk("R10 busy dropped", {31'b0, drain_busy}, 32'h0);
        chk("R10 eject count", 32'(log_n), 32'd4);
        chk("R10 order 0", {24'b0, log_e[0]}, {24'b0, 3'd0, 5'd7});
        chk("R10 order 1", {24'b0, log_e[1]}, {24'b0, 3'd2, 5'd1});
        chk("R10 order 2", {24'b0, log_e[2]}, {24'b0, 3'd2, 5'd6});
        chk("R10 order 3", {24'b0, log_e[3]}, {24'b0, 3'd5, 5'd31});
        rdreg(5'h10, rd); chk("R10 write while busy ignored", rd, 32'h3);
        wr(5'h10, 32'd0);
        rdreg(5'h04, rd); chk("R10 bus0 down drained", rd, 32'h0);
        rdreg(5'h00, rd); chk("R10 bus0 up slot7 cleared", rd, 32'h2);
        wr(5'h10, 32'd6);
        rdreg(5'h0C, rd); chk("R10 removable reloaded", rd, 32'h0000_FFFF);
    endtask

    initial begin
        for (int b = 0; b < 8; b++) fixed_mask[b*32 +: 32] = 32'h1 << (b + 3);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_events;
        t_legacy;
        t_collide;
        t_eject;
        t_range;
        t_partial;
        t_drain;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule